// File: doc/BRIEF.md
# I/O Command Processor with Descriptor Fetch

This block takes device transfers off the CPU. The CPU hands it a short command made of an operation code and a device number. The block then reads a three-word descriptor for that device from memory. The descriptor gives the transfer direction, the memory start address and the word count. The block then moves the data between the device streams and memory by itself, taking memory cycles through a request/grant master port. When the work is finished, or when it cannot be done, it raises a one-cycle interrupt. A status bit beside the interrupt marks a failure.

The command port and both device data ports are valid/ready streams. A transfer happens on a clock edge where valid and ready are both high. A source that raises valid keeps it high, with its data unchanged, until the transfer takes place. The memory port is a plain request/grant pair. While a request waits for its grant, the block holds the request, the address and the write-enable steady. Read data is taken from `mem_rdata` in the cycle the grant arrives. Back-pressure from memory stalls the device input stream, because a device word is accepted only in a cycle in which its memory write is granted. Back-pressure from the device output stream stalls the next memory read, because only one word is held at a time.

Top module: `iop_engine`

## Requirements
- R1: `cmd_ready` is high only while the block is idle. After a command is accepted it stays low until the cycle after the interrupt pulse.
- R2: CPU operation code 1 starts a descriptor fetch. Any other CPU operation code completes with `irq` and `irq_err` both high and makes no memory access.
- R3: The descriptor for device `d` is read at addresses BASE+4·d, BASE+4·d+1 and BASE+4·d+2, in that order. These three words hold the direction code, the start address (low AW bits) and the word count (low CW bits). While a request waits for its grant, it is held steady.
- R4: With direction code 0, each word taken from the device input stream is written to memory at the current address. The address then increases by one.
- R5: With direction code 1, memory is read from the current address upward, and the words are sent on the device output stream in address order. `dev_tx_data` stays stable while `dev_tx_valid` waits for ready.
- R6: Exactly as many words as the count field are moved. Memory sees exactly 3 + count granted accesses. A count of 0 moves nothing and completes without error.
- R7: A direction code other than 0 or 1 completes with `irq_err` high, after the three descriptor reads only. No data is moved.
- R8: `irq` is a single-cycle pulse, one per accepted command. `irq_err` is high only together with `irq`.
- R9: `dev_rx_ready` is high only in a cycle in which the memory write for that word is requested and granted.
- R10: During reset and right after it, `cmd_ready` is 1 and `mem_req`, `dev_rx_ready`, `dev_tx_valid`, `irq` and `irq_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | CPU command valid |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | OPW | CPU operation code (1 = start) |
| cmd_dev | input | DEVW | Target device number |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write data |
| mem_gnt | input | 1 | Memory grant, access completes this cycle |
| mem_rdata | input | DW | Read data, valid with the grant |
| dev_rx_valid | input | 1 | Device-to-memory word valid |
| dev_rx_ready | output | 1 | Device word accepted |
| dev_rx_data | input | DW | Device-to-memory word |
| dev_tx_valid | output | 1 | Memory-to-device word valid |
| dev_tx_ready | input | 1 | Device can take a word |
| dev_tx_data | output | DW | Memory-to-device word |
| irq | output | 1 | Completion interrupt pulse |
| irq_err | output | 1 | Failure status, meaningful with irq |

## Verification
The hardest situation to reach is one where memory grants and device handshakes are withheld independently on the same word. An example is a device input word that waits while memory refuses the grant, with the address and request held across the stall. Another is an output word held on the stream while the next read is already due. The bench withholds the grant, the input valid and the output ready at random on every cycle, with separate probabilities, across many random transfers. It then compares memory contents, captured output words and the count of granted accesses with values worked out from the descriptor alone.

// File: rtl/iop_pkg.sv
package iop_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_XFER,
    ST_DONE
  } iop_state_e;

  localparam int unsigned DIR_DEV2MEM = 0;
  localparam int unsigned DIR_MEM2DEV = 1;
  localparam int unsigned CPU_OP_START = 1;
  localparam int unsigned DESC_WORDS = 3;
endpackage

// File: rtl/iop_desc_fetch.sv
module iop_desc_fetch #(
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int CW   = 8,
  parameter int DEVW = 4,
  parameter int BASE = 192
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [DEVW-1:0] dev_i,
  input  logic            gnt_i,
  input  logic [DW-1:0]   rdata_i,
  output logic            req_o,
  output logic [AW-1:0]   addr_o,
  output logic            done_o,
  output logic [DW-1:0]   op_o,
  output logic [AW-1:0]   daddr_o,
  output logic [CW-1:0]   cnt_o
);
  localparam int IW = 2;
  localparam logic [IW-1:0] LAST_IDX = IW'(iop_pkg::DESC_WORDS - 1);
  localparam logic [AW-1:0] BASE_A = AW'(BASE);

  logic            busy_q;
  logic [IW-1:0]   idx_q;
  logic [DEVW-1:0] dev_q;
  logic            done_q;
  logic [DW-1:0]   op_q;
  logic [AW-1:0]   daddr_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      dev_q   <= '0;
      done_q  <= 1'b0;
      op_q    <= '0;
      daddr_q <= '0;
      cnt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        dev_q  <= dev_i;
      end else if (busy_q && gnt_i) begin
        case (idx_q)
          2'd0:    op_q    <= rdata_i;
          2'd1:    daddr_q <= rdata_i[AW-1:0];
          default: cnt_q   <= rdata_i[CW-1:0];
        endcase
        if (idx_q == LAST_IDX) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign req_o   = busy_q;
  assign addr_o  = BASE_A + AW'({dev_q, 2'b00}) + AW'(idx_q);
  assign done_o  = done_q;
  assign op_o    = op_q;
  assign daddr_o = daddr_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/iop_xfer.sv
module iop_xfer #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          dir_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          gnt_i,
  input  logic [DW-1:0] rdata_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic          rx_valid_i,
  output logic          rx_ready_o,
  input  logic [DW-1:0] rx_data_i,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic [DW-1:0] tx_data_o,
  output logic          done_o
);
  logic          busy_q;
  logic          dir_q;
  logic          held_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] hold_q;
  logic          done_q;

  logic d2m, m2d, wfire, rfire, tfire, step;

  always_comb begin
    d2m   = busy_q && (dir_q == 1'(iop_pkg::DIR_DEV2MEM));
    m2d   = busy_q && (dir_q == 1'(iop_pkg::DIR_MEM2DEV));
    wfire = d2m && rx_valid_i && gnt_i;
    rfire = m2d && !held_q && gnt_i;
    tfire = m2d && held_q && tx_ready_i;
    step  = wfire || tfire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      held_q <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
      hold_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        dir_q  <= dir_i;
        held_q <= 1'b0;
        addr_q <= addr_i;
        cnt_q  <= cnt_i;
      end else begin
        if (rfire) begin
          hold_q <= rdata_i;
          held_q <= 1'b1;
        end
        if (tfire) held_q <= 1'b0;
        if (step) begin
          addr_q <= addr_q + 1'b1;
          cnt_q  <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign req_o      = (d2m && rx_valid_i) || (m2d && !held_q);
  assign we_o       = d2m;
  assign addr_o     = addr_q;
  assign wdata_o    = rx_data_i;
  assign rx_ready_o = wfire;
  assign tx_valid_o = m2d && held_q;
  assign tx_data_o  = hold_q;
  assign done_o     = done_q;
endmodule

// File: rtl/iop_engine.sv
module iop_engine #(
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int CW   = 8,
  parameter int DEVW = 4,
  parameter int OPW  = 4,
  parameter int BASE = 192
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [OPW-1:0]  cmd_op,
  input  logic [DEVW-1:0] cmd_dev,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_gnt,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            dev_rx_valid,
  output logic            dev_rx_ready,
  input  logic [DW-1:0]   dev_rx_data,
  output logic            dev_tx_valid,
  input  logic            dev_tx_ready,
  output logic [DW-1:0]   dev_tx_data,
  output logic            irq,
  output logic            irq_err
);
  import iop_pkg::*;

  iop_state_e state_q;
  logic       err_q;

  logic          f_start, f_req, f_done;
  logic [AW-1:0] f_addr, f_daddr;
  logic [DW-1:0] f_op;
  logic [CW-1:0] f_cnt;

  logic          x_start, x_req, x_we, x_done;
  logic [AW-1:0] x_addr;
  logic [DW-1:0] x_wdata;

  logic accept, op_ok, dir_ok, cnt_zero;

  always_comb begin
    accept   = (state_q == ST_IDLE) && cmd_valid;
    op_ok    = (cmd_op == OPW'(CPU_OP_START));
    dir_ok   = (f_op == DW'(DIR_DEV2MEM)) || (f_op == DW'(DIR_MEM2DEV));
    cnt_zero = (f_cnt == '0);
    f_start  = accept && op_ok;
    x_start  = (state_q == ST_FETCH) && f_done && dir_ok && !cnt_zero;
  end

  iop_desc_fetch #(.AW(AW), .DW(DW), .CW(CW), .DEVW(DEVW), .BASE(BASE)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start_i(f_start), .dev_i(cmd_dev),
    .gnt_i(mem_gnt && (state_q == ST_FETCH)), .rdata_i(mem_rdata),
    .req_o(f_req), .addr_o(f_addr), .done_o(f_done),
    .op_o(f_op), .daddr_o(f_daddr), .cnt_o(f_cnt)
  );

  iop_xfer #(.AW(AW), .DW(DW), .CW(CW)) u_xfer (
    .clk(clk), .rst_n(rst_n), .start_i(x_start), .dir_i(f_op[0]),
    .addr_i(f_daddr), .cnt_i(f_cnt),
    .gnt_i(mem_gnt && (state_q == ST_XFER)), .rdata_i(mem_rdata),
    .req_o(x_req), .we_o(x_we), .addr_o(x_addr), .wdata_o(x_wdata),
    .rx_valid_i(dev_rx_valid), .rx_ready_o(dev_rx_ready), .rx_data_i(dev_rx_data),
    .tx_valid_o(dev_tx_valid), .tx_ready_i(dev_tx_ready), .tx_data_o(dev_tx_data),
    .done_o(x_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          if (op_ok) begin
            state_q <= ST_FETCH;
          end else begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end
        end
        ST_FETCH: if (f_done) begin
          if (!dir_ok) begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end else if (cnt_zero) begin
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_XFER;
          end
        end
        ST_XFER: if (x_done) state_q <= ST_DONE;
        default: begin
          err_q   <= 1'b0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    if (state_q == ST_FETCH) begin
      mem_req  = f_req;
      mem_addr = f_addr;
    end else if (state_q == ST_XFER) begin
      mem_req   = x_req;
      mem_we    = x_we;
      mem_addr  = x_addr;
      mem_wdata = x_wdata;
    end
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign irq       = (state_q == ST_DONE);
  assign irq_err   = (state_q == ST_DONE) && err_q;
endmodule

// File: rtl/iop_engine_chk.sv
module iop_engine_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_gnt,
  input logic          dev_rx_ready,
  input logic          dev_tx_valid,
  input logic          dev_tx_ready,
  input logic [DW-1:0] dev_tx_data,
  input logic          irq,
  input logic          irq_err
);
  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_tx_valid && !dev_tx_ready) |=> (dev_tx_valid && $stable(dev_tx_data)));

  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_err_with_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> irq);

  p_rx_needs_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rx_ready |-> (mem_req && mem_we && mem_gnt));

  p_irq_ready_after_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !cmd_ready);
endmodule

bind iop_engine iop_engine_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_iop_engine.sv
`timescale 1ns/1ps
module test_iop_engine;
  localparam int AW = 8, DW = 16, CW = 8, DEVW = 4, OPW = 4, BASE = 192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [OPW-1:0] cmd_op = '0;
  logic [DEVW-1:0] cmd_dev = '0;
  logic mem_req, mem_we, mem_gnt = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic dev_rx_valid = 1'b0;
  logic dev_rx_ready;
  logic [DW-1:0] dev_rx_data;
  logic dev_tx_valid;
  logic dev_tx_ready = 1'b0;
  logic [DW-1:0] dev_tx_data;
  logic irq, irq_err;

  always #2 clk = ~clk;

  logic [DW-1:0] bmem [256];
  logic [DW-1:0] snap [256];
  logic [DW-1:0] rxbuf [1024];
  logic [DW-1:0] txcap [1024];
  int rx_idx = 0;
  int tx_n = 0;
  int acc_n = 0;
  int irq_n = 0;
  logic rx_took = 1'b0;
  int n_tests = 0, n_fail = 0, cyc = 0;
  int gnt_pct = 75, rx_pct = 70, tx_pct = 70;

  assign mem_rdata   = bmem[mem_addr];
  assign dev_rx_data = rxbuf[rx_idx[9:0]];

  iop_engine #(.AW(AW), .DW(DW), .CW(CW), .DEVW(DEVW), .OPW(OPW), .BASE(BASE)) i_iop_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_dev(cmd_dev), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .dev_rx_valid(dev_rx_valid), .dev_rx_ready(dev_rx_ready), .dev_rx_data(dev_rx_data),
    .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready), .dev_tx_data(dev_tx_data),
    .irq(irq), .irq_err(irq_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rx_took <= dev_rx_valid && dev_rx_ready;
    if (mem_req && mem_gnt) begin
      acc_n <= acc_n + 1;
      if (mem_we) bmem[mem_addr] <= mem_wdata;
    end
    if (dev_rx_valid && dev_rx_ready) rx_idx <= rx_idx + 1;
    if (dev_tx_valid && dev_tx_ready) begin
      txcap[tx_n[9:0]] <= dev_tx_data;
      tx_n <= tx_n + 1;
    end
    if (irq) irq_n <= irq_n + 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      mem_gnt      <= ($urandom % 100) < gnt_pct;
      dev_tx_ready <= ($urandom % 100) < tx_pct;
      if (!dev_rx_valid || rx_took) dev_rx_valid <= ($urandom % 100) < rx_pct;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    finish_run();
  end

  function automatic bit exp_err(input int cop, input int dop);
    return (cop != 1) || (dop > 1);
  endfunction

  function automatic int exp_acc(input int cop, input int dop, input int cnt);
    if (cop != 1) return 0;
    if (dop > 1) return 3;
    return 3 + cnt;
  endfunction

  task automatic run_cmd(input int cop, input int dev, input int dop,
                         input int daddr, input int cnt);
    int rx0, tx0, acc0, irq0, waited;
    bit got, e;
    int base = BASE + dev * 4;
    bmem[base]     = DW'(dop);
    bmem[base + 1] = DW'(daddr);
    bmem[base + 2] = DW'(cnt);
    for (int i = 0; i <= cnt; i++) bmem[(daddr + i) % 256] = DW'($urandom);
    for (int i = 0; i < 256; i++) snap[i] = bmem[i];
    @(negedge clk);
    rx0 = rx_idx; tx0 = tx_n; acc0 = acc_n; irq0 = irq_n;
    cmd_valid = 1'b1; cmd_op = OPW'(cop); cmd_dev = DEVW'(dev);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    // R1: busy once accepted
    check(cmd_ready == 1'b0, "R1 busy after accept", cmd_ready, 0);
    got = 0; e = 0; waited = 0;
    while (!got && waited < 3000) begin
      if (irq) begin got = 1; e = irq_err; end
      else begin @(negedge clk); waited++; end
    end
    check(got, "R8 irq raised", got, 1);
    check(cmd_ready == 1'b0, "R1 not ready during irq", cmd_ready, 0);
    @(negedge clk);
    check(irq == 1'b0, "R8 irq single cycle", irq, 0);
    check(cmd_ready == 1'b1, "R1 ready after irq", cmd_ready, 1);
    check(irq_n - irq0 == 1, "R8 one irq per command", irq_n - irq0, 1);
    check(e == exp_err(cop, dop), "R2/R7 irq_err value", e, exp_err(cop, dop));
    check(acc_n - acc0 == exp_acc(cop, dop, cnt), "R6 granted access count R3",
          acc_n - acc0, exp_acc(cop, dop, cnt));
    if (cop == 1 && dop == 0) begin
      for (int i = 0; i < cnt; i++)
        check(bmem[(daddr + i) % 256] == rxbuf[(rx0 + i) % 1024], "R4 word written",
              bmem[(daddr + i) % 256], rxbuf[(rx0 + i) % 1024]);
      check(rx_idx - rx0 == cnt, "R6 rx words consumed", rx_idx - rx0, cnt);
      check(bmem[(daddr + cnt) % 256] == snap[(daddr + cnt) % 256], "R6 word past end untouched",
            bmem[(daddr + cnt) % 256], snap[(daddr + cnt) % 256]);
    end else if (cop == 1 && dop == 1) begin
      check(tx_n - tx0 == cnt, "R6 tx words sent", tx_n - tx0, cnt);
      for (int i = 0; i < cnt; i++)
        check(txcap[(tx0 + i) % 1024] == snap[(daddr + i) % 256], "R5 word order",
              txcap[(tx0 + i) % 1024], snap[(daddr + i) % 256]);
    end else begin
      check(tx_n == tx0 && rx_idx == rx0, "R7/R2 no data moved", tx_n - tx0 + rx_idx - rx0, 0);
      for (int i = 0; i <= cnt; i++)
        check(bmem[(daddr + i) % 256] == snap[(daddr + i) % 256], "R7 memory unchanged",
              bmem[(daddr + i) % 256], snap[(daddr + i) % 256]);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) bmem[i] = DW'($urandom);
    for (int i = 0; i < 1024; i++) rxbuf[i] = DW'($urandom);
    repeat (3) @(negedge clk);
    // R10: reset state
    check(cmd_ready == 1'b1, "R10 cmd_ready in reset", cmd_ready, 1);
    check(!mem_req && !dev_rx_ready && !dev_tx_valid, "R10 outputs idle in reset",
          mem_req + dev_rx_ready + dev_tx_valid, 0);
    check(!irq && !irq_err, "R10 irq low in reset", irq + irq_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1 && !mem_req, "R10 idle after reset", cmd_ready, 1);

    run_cmd(1, 2, 0, 16, 3);     // R4 device to memory
    run_cmd(1, 15, 1, 40, 4);    // R5 memory to device, last descriptor slot R3
    run_cmd(1, 0, 0, 60, 0);     // R6 zero count
    run_cmd(1, 7, 5, 70, 4);     // R7 bad direction code
    run_cmd(3, 4, 0, 80, 2);     // R2 bad CPU opcode
    run_cmd(0, 4, 1, 80, 2);     // R2 opcode zero
    gnt_pct = 20; rx_pct = 90; tx_pct = 15;
    run_cmd(1, 9, 0, 100, 6);    // R9 stalls on grant
    run_cmd(1, 9, 1, 120, 6);    // R5 stalls on output ready
    gnt_pct = 100; rx_pct = 100; tx_pct = 100;
    run_cmd(1, 1, 0, 150, 5);    // full rate
    run_cmd(1, 1, 1, 150, 5);
    for (int t = 0; t < 30; t++) begin
      gnt_pct = 20 + int'($urandom % 81);
      rx_pct  = 20 + int'($urandom % 81);
      tx_pct  = 20 + int'($urandom % 81);
      run_cmd(($urandom % 8 == 0) ? 2 : 1, int'($urandom % 16),
              ($urandom % 6 == 0) ? 2 + int'($urandom % 5) : int'($urandom % 2),
              int'($urandom % 170), int'($urandom % 16));
    end
    finish_run();
  end
endmodule